// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of general-purpose inputs and turns their activity into interrupt requests. Every pin has its own trigger set by static configuration inputs from a register bank: level or edge, active polarity, an any-transition mode, an optional debounce filter, an enable and a mask. The block takes the asynchronous pins through a two-flop synchroniser. It then applies the filter where it is enabled. Edge events are held until software clears them bit by bit with an end-of-interrupt vector.

Three outputs are produced. The raw status shows every enabled pin that is currently requesting. The masked status hides the pins whose mask bit is set. A single interrupt line is the OR of the masked status. The register bank that drives the configuration inputs is not part of this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, raw_status, masked_status and irq are all 0.
- R2: A pin change reaches the detector through two synchronising flops: a level-mode pin that changes just before clock edge k shows its new raw status after edge k+1 and not before.
- R3: With edge_type bit 0 (level mode), the raw bit is 1 while the filtered pin equals its polarity bit. polarity 1 means active high, polarity 0 means active low. eoi has no effect on it.
- R4: With edge_type bit 1 and any_edge bit 0, a rising transition (polarity 1) or a falling transition (polarity 0) sets the raw bit and it stays set.
- R5: With edge_type bit 1 and any_edge bit 1, both rising and falling transitions set the raw bit, regardless of polarity.
- R6: A pin whose enable bit is 0 never shows a raw bit, and a latched event is dropped while enable is 0.
- R7: masked_status equals raw_status with every bit whose mask bit is 1 forced to 0. A mask bit never changes raw_status.
- R8: irq is 1 exactly when masked_status is nonzero.
- R9: A 1 on an eoi bit for one cycle clears that pin's latched edge event.
- R10: If an edge event and an eoi for the same pin fall in the same cycle, the event wins and the raw bit stays 1.
- R11: With debounce enabled, the filtered value takes a new level only after the synchronised pin has held it for DEB_TICKS consecutive debounce ticks (deb_tick high). Shorter pulses are discarded.

Top module port list order matches the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Asynchronous pin levels |
| deb_tick | input | 1 | Debounce sampling strobe |
| irq_en | input | NPINS | Per-pin enable |
| irq_mask | input | NPINS | Per-pin mask (1 hides) |
| edge_type | input | NPINS | 1 edge, 0 level |
| polarity | input | NPINS | 1 high/rising, 0 low/falling |
| any_edge | input | NPINS | 1 triggers on both transitions in edge mode |
| deb_en | input | NPINS | Per-pin debounce enable |
| eoi | input | NPINS | Per-bit clear of latched edge events |
| raw_status | output | NPINS | Unmasked request per pin |
| masked_status | output | NPINS | raw_status with masked bits removed |
| irq | output | 1 | OR of masked_status |

## Verification
Random rounds draw a fresh configuration for all 32 pins and apply a settled old value and a new value to the pins. Because every pin is in a different mode in the same round, one vector tells level from edge handling, rising from falling, and single from any-transition detection. A follow-up eoi pulse in the same round separates latched edge bits from level bits, which must survive it. Directed cases cover the exact synchroniser delay, an event colliding with eoi in the same cycle, and a short glitch that the debounce filter rejects next to a long pulse it accepts.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Edge request from a one-cycle transition pair
  function automatic logic edge_hit(input logic rise, input logic fall,
                                    input logic pol, input logic any);
    if (any) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level request: the pin sits at its active level
  function automatic logic level_hit(input logic v, input logic pol);
    return v == pol;
  endfunction

  // Next state of a latched event bit; a new event beats the clear
  function automatic logic latch_next(input logic cur, input logic ev,
                                      input logic clr, input logic keep);
    if (!keep) return 1'b0;
    return ev | (cur & ~clr);
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  // R2: the second stage always carries what the first held one cycle earlier
  assert_sync_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(meta));
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int DEB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sin,
  input  logic tick,
  input  logic enable,
  output logic filt
);
  localparam int CW = (DEB_TICKS > 2) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic          held;
  logic [CW-1:0] cnt;
  logic          differs;
  logic          commit;

  assign differs = sin != held;
  assign commit  = enable && differs && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      cnt  <= '0;
    end else if (!enable) begin
      held <= sin;
      cnt  <= '0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) begin
        held <= sin;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign filt = enable ? held : sin;

  // R11: while filtering, the held level moves only on a tick
  assert_deb_tick_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(held) || !$past(enable));
  // R11: a commit always lands the synchronised value
  assert_deb_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> held == $past(sin));
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic filt,
  input  logic en,
  input  logic etype,
  input  logic pol,
  input  logic any,
  input  logic clr,
  output logic ev,
  output logic raw
);
  logic prev;
  logic latched;
  logic rise;
  logic fall;
  logic keep;

  assign rise = filt & ~prev;
  assign fall = ~filt & prev;
  assign keep = en & etype;
  assign ev   = keep & edge_hit(rise, fall, pol, any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      latched <= 1'b0;
    end else begin
      prev    <= filt;
      latched <= latch_next(latched, ev, clr, keep);
    end
  end

  always_comb begin
    if (!en)        raw = 1'b0;
    else if (etype) raw = latched;
    else            raw = level_hit(filt, pol);
  end

  // R4/R5/R10: an event is latched next cycle, even against a clear
  assert_event_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> latched);
  // R9: a clear without a new event drops the latch
  assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev) |=> !latched);
  // R6: a disabled pin holds nothing
  assert_disabled_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !latched);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS     = 32,
  parameter int DEB_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             deb_tick,
  input  logic [NPINS-1:0] irq_en,
  input  logic [NPINS-1:0] irq_mask,
  input  logic [NPINS-1:0] edge_type,
  input  logic [NPINS-1:0] polarity,
  input  logic [NPINS-1:0] any_edge,
  input  logic [NPINS-1:0] deb_en,
  input  logic [NPINS-1:0] eoi,
  output logic [NPINS-1:0] raw_status,
  output logic [NPINS-1:0] masked_status,
  output logic             irq
);
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] filt;
  logic [NPINS-1:0] ev_vec;

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .sin(sync_q[i]), .tick(deb_tick),
      .enable(deb_en[i]), .filt(filt[i])
    );
    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n), .filt(filt[i]), .en(irq_en[i]),
      .etype(edge_type[i]), .pol(polarity[i]), .any(any_edge[i]),
      .clr(eoi[i]), .ev(ev_vec[i]), .raw(raw_status[i])
    );
  end

  assign masked_status = raw_status & ~irq_mask;
  assign irq           = |masked_status;

  // R6: disabled pins never request
  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status & ~irq_en) == '0);
  // R7: masked bits never appear in the masked view
  assert_mask_hides_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status & irq_mask) == '0);
  // R8: the line is high only with some unmasked request
  assert_line_needs_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_status & ~irq_mask) != '0));
  // R4: an event at the pins shows up in raw status next cycle
  assert_event_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != '0) |=> ((raw_status & $past(ev_vec)) == $past(ev_vec)) ||
                       ($past(ev_vec) & ~(irq_en & edge_type)) != '0);
endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int N = 32;
  localparam int DT = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] pin_in = '0, irq_en = '0, irq_mask = '0, edge_type = '0;
  logic [N-1:0] polarity = '0, any_edge = '0, deb_en = '0, eoi = '0;
  logic deb_tick = 1'b1;
  logic [N-1:0] raw_status, masked_status;
  logic irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NPINS(N), .DEB_TICKS(DT)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .deb_tick(deb_tick),
    .irq_en(irq_en), .irq_mask(irq_mask), .edge_type(edge_type),
    .polarity(polarity), .any_edge(any_edge), .deb_en(deb_en), .eoi(eoi),
    .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected request per pin after a settled transition old -> new
  function automatic logic [N-1:0] model_raw(input logic [N-1:0] o, input logic [N-1:0] n,
                                             input logic [N-1:0] en, input logic [N-1:0] ty,
                                             input logic [N-1:0] po, input logic [N-1:0] an);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (!en[i]) r[i] = 1'b0;
      else if (!ty[i]) r[i] = (n[i] == po[i]);
      else if (an[i]) r[i] = (o[i] != n[i]);
      else if (po[i]) r[i] = (!o[i] && n[i]);
      else r[i] = (o[i] && !n[i]);
    end
    return r;
  endfunction

  function automatic logic [N-1:0] model_level(input logic [N-1:0] n, input logic [N-1:0] en,
                                               input logic [N-1:0] ty, input logic [N-1:0] po);
    return en & ~ty & ~(n ^ po);
  endfunction

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [N-1:0] o, n, exp;
    void'($urandom(32'd2024));
    cyc(3);
    check("R1 raw", raw_status, '0);
    check("R1 masked", masked_status, '0);
    check("R1 irq", {31'd0, irq}, '0);
    rst_n = 1;
    cyc(2);

    // R2: synchroniser latency, level-high on pin 0
    irq_en = 32'h1; polarity = 32'h1; edge_type = '0;
    cyc(3);
    pin_in[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 one edge", raw_status, '0);
    @(posedge clk); @(negedge clk);
    check("R2 two edges", raw_status, 32'h1);
    // R3: eoi leaves a level request alone
    eoi = '1; cyc(1); eoi = '0; cyc(1);
    check("R3 eoi no effect", raw_status, 32'h1);
    pin_in[0] = 1'b0; cyc(4);
    check("R3 level drop", raw_status, '0);

    // R10: rising event on pin 3 collides with eoi
    irq_en = 32'h8; edge_type = 32'h8; polarity = 32'h8; any_edge = '0;
    cyc(4);
    pin_in[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); eoi = 32'h8;
    @(negedge clk); eoi = '0;
    check("R10 event beats eoi", raw_status, 32'h8);
    eoi = 32'h8; cyc(1); eoi = '0; cyc(1);
    check("R9 eoi clears", raw_status, '0);
    // R6: disable drops the latch
    pin_in[3] = 1'b0; cyc(3); pin_in[3] = 1'b1; cyc(5);
    check("R4 rising latched", raw_status, 32'h8);
    irq_en = '0; cyc(1); irq_en = 32'h8; cyc(1);
    check("R6 latch dropped", raw_status, '0);

    // R11: debounce on pin 5, level high
    pin_in = '0; irq_en = 32'h20; edge_type = '0; polarity = 32'h20; deb_en = 32'h20;
    cyc(6);
    pin_in[5] = 1'b1; cyc(2); pin_in[5] = 1'b0; cyc(8);
    check("R11 glitch rejected", raw_status, '0);
    pin_in[5] = 1'b1; cyc(4);
    check("R11 not yet", raw_status, '0);
    cyc(4);
    check("R11 long pulse", raw_status, 32'h20);
    deb_en = '0; pin_in = '0; cyc(4);

    // Random rounds, debounce off
    for (int r = 0; r < 40; r++) begin
      o = $urandom; n = $urandom;
      irq_en = $urandom | $urandom; edge_type = $urandom; polarity = $urandom;
      any_edge = $urandom; irq_mask = $urandom;
      pin_in = o; cyc(6);
      eoi = '1; cyc(1); eoi = '0; cyc(2);
      pin_in = n; cyc(6);
      exp = model_raw(o, n, irq_en, edge_type, polarity, any_edge);
      check("R3/R4/R5/R6 raw", raw_status, exp);
      check("R7 masked", masked_status, exp & ~irq_mask);
      check("R8 irq", {31'd0, irq}, {31'd0, |(exp & ~irq_mask)});
      eoi = '1; cyc(1); eoi = '0; cyc(1);
      check("R9 after eoi", raw_status, model_level(n, irq_en, edge_type, polarity));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule